// File: doc/BRIEF.md
# Indexed-Colour Framebuffer Scan-Out

This block is the pixel source of a simple display path. It stores a screen image of 4-bit colour indices in a dual-clock memory and holds a 16-entry palette of 24-bit colours. On the CPU side, software writes pixels and palette entries through a write-only, memory-mapped port on the CPU clock. There is no handshake with the display side. On the video side, a timing generator on its own pixel clock walks the raster. Each pixel is read from the framebuffer and looked up in the palette. The resulting RGB colour is presented together with the horizontal sync, vertical sync and blank flag of that same position.

The raster geometry is a set of parameters. The display configuration is 1024x768 at 75 Hz on a 78.75 MHz pixel clock, set up as follows:

| Axis | Active | Front porch | Sync | Back porch | Total |
|------|--------|-------------|------|------------|-------|
| Horizontal | 1024 | 16 | 96 | 176 | 1312 clocks per line |
| Vertical | 768 | 1 | 3 | 28 | 800 lines per frame |

The default parameter values describe a reduced 16x12 screen with short porches. This keeps the memory small when the block is elaborated and simulated on its own. The CPU address map does not depend on the geometry:

- Pixel word index is `y*HACT + x`, at byte address `0x8000_0000 + 4*index`, inside a 4 MiB decode window.
- Palette entry `n` is at byte address `0x8040_0000 + 4*n`.

Top module: `fb_scanout`

## Requirements
- R1: While the pixel-side reset is held, the video outputs are rgb = 0, hsync = 0, vsync = 0 and blank = 1.
- R2: A line lasts HACT+HFP+HSYNC+HBP pixel clocks and a frame lasts VACT+VFP+VSYNC+VBP lines. Blank is low exactly when the column is below HACT and the line is below VACT.
- R3: Hsync is high (active-high) for HSYNC clocks, starting at column HACT+HFP. Vsync is high for the whole of lines VACT+VFP through VACT+VFP+VSYNC-1.
- R4: A CPU write with address bits [31:22] = 0x200 stores data bits [3:0] at word index address[21:2]. Pixel (x,y) is index y*HACT+x. Data bits [31:4] are discarded.
- R5: While blank is high, rgb is zero.
- R6: A CPU write with address bits [31:6] = 0x201_0000 loads palette entry address[5:2] with data[23:0] (red [23:16], green [15:8], blue [7:0]). A visible pixel's rgb equals the palette entry selected by its stored index.
- R7: Colour, syncs and blank of a position appear together, two pixel clocks after the raster counter reaches it. The first pixel after reset release appears on the second rising edge.
- R8: These writes leave the framebuffer and the palette unchanged:
  - a write with cpuWe low;
  - a framebuffer-window write whose word index is at or beyond HACT*VACT;
  - a write outside both windows.
- R9: Rewriting only the palette changes the colour of every pixel on the next frame, with no framebuffer write.
- R10: Pixels are scanned in raster order: left to right within a line, top line first, with (0,0) the first visible position of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | CPU-side clock |
| cpuRstN | input | 1 | CPU-side asynchronous reset, active low (clears the palette) |
| cpuWe | input | 1 | Write strobe |
| cpuAddr | input | 32 | Byte address of the write |
| cpuWdata | input | 32 | Write data |
| pixClk | input | 1 | Pixel clock |
| pixRstN | input | 1 | Pixel-side asynchronous reset, active low |
| vidRgb | output | 24 | Pixel colour, red in [23:16] |
| vidHsync | output | 1 | Horizontal sync, active high |
| vidVsync | output | 1 | Vertical sync, active high |
| vidBlank | output | 1 | High outside the visible area |

## Verification
Some properties are checked by assertions on every pixel clock:
- the counter stepping, line wrap and frame wrap of the raster;
- black output whenever blank is high;
- vsync only inside blanking;
- the two-cycle alignment of the syncs with the counter that produced them.

On the CPU clock, an assertion checks that no framebuffer write reaches an index beyond the visible area. The colour content depends on memory and palette state that no single-cycle property can see. The bench therefore scans whole frames against its own model of the image:

- the index-to-colour mapping;
- raster order;
- the handling of ignored and aliasing writes;
- a palette-only recolour.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam logic [31:0] FB_BASE     = 32'h8000_0000;
  localparam logic [31:0] PAL_BASE    = 32'h8040_0000;
  localparam int          PIX_BITS    = 4;
  localparam int          PAL_ENTRIES = 1 << PIX_BITS;
  localparam int          COLOR_BITS  = 24;

  typedef logic [PIX_BITS-1:0]   pix_t;
  typedef logic [COLOR_BITS-1:0] color_t;

  // Strobes handed from the raster control to the datapath.
  typedef struct packed {
    logic visible;
    logic hsync;
    logic vsync;
  } scan_strb_t;
endpackage

// File: rtl/fb_scan_timing.sv
module fb_scan_timing
  import fb_scan_pkg::*;
#(
  parameter int HACT  = 16,
  parameter int HFP   = 2,
  parameter int HSYNC = 3,
  parameter int HBP   = 4,
  parameter int VACT  = 12,
  parameter int VFP   = 1,
  parameter int VSYNC = 2,
  parameter int VBP   = 3,
  parameter int IDX_W = 8
) (
  input  logic             pixClk,
  input  logic             pixRstN,
  output scan_strb_t       strobe,
  output logic [IDX_W-1:0] rdIdx
);
  localparam int HTOT = HACT + HFP + HSYNC + HBP;
  localparam int VTOT = VACT + VFP + VSYNC + VBP;
  localparam int HW   = $clog2(HTOT);
  localparam int VW   = $clog2(VTOT);

  localparam logic [HW-1:0] H_LAST   = HW'(HTOT - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(VTOT - 1);
  localparam logic [HW-1:0] H_ACT    = HW'(HACT);
  localparam logic [HW-1:0] H_SYN_LO = HW'(HACT + HFP);
  localparam logic [HW-1:0] H_SYN_HI = HW'(HACT + HFP + HSYNC);
  localparam logic [VW-1:0] V_ACT    = VW'(VACT);
  localparam logic [VW-1:0] V_SYN_LO = VW'(VACT + VFP);
  localparam logic [VW-1:0] V_SYN_HI = VW'(VACT + VFP + VSYNC);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          lineEnd;
  logic          frameEnd;

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = lineEnd && (vCnt == V_LAST);

  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.visible = (hCnt < H_ACT) && (vCnt < V_ACT);
    strobe.hsync   = (hCnt >= H_SYN_LO) && (hCnt < H_SYN_HI);
    strobe.vsync   = (vCnt >= V_SYN_LO) && (vCnt < V_SYN_HI);
    rdIdx = strobe.visible ? IDX_W'(int'(vCnt) * HACT + int'(hCnt)) : '0;
  end

  // R2: column counter steps by one inside a line, line counter holds
  p_line_step_r2: assert property (@(posedge pixClk) disable iff (!pixRstN)
    !lineEnd |=> (hCnt == $past(hCnt) + 1'b1) && $stable(vCnt));

  // R2: column counter wraps after the last clock of a line
  p_line_wrap_r2: assert property (@(posedge pixClk) disable iff (!pixRstN)
    lineEnd |=> (hCnt == '0));

  // R2: line counter wraps after the last line of a frame
  p_frame_wrap_r2: assert property (@(posedge pixClk) disable iff (!pixRstN)
    frameEnd |=> (vCnt == '0));
endmodule

// File: rtl/fb_cpu_port.sv
module fb_cpu_port
  import fb_scan_pkg::*;
#(
  parameter int DEPTH = 192,
  parameter int IDX_W = 8
) (
  input  logic             cpuWe,
  input  logic [31:0]      cpuAddr,
  input  logic [31:0]      cpuWdata,
  output logic             fbWe,
  output logic [IDX_W-1:0] fbIdx,
  output pix_t             fbData,
  output logic             palWe,
  output logic [PIX_BITS-1:0] palSel,
  output color_t           palData
);
  logic [19:0] wordIdx;
  logic        fbHit;
  logic        palHit;
  logic        inRange;
  logic        unusedCpuBits;

  assign wordIdx       = cpuAddr[21:2];
  assign fbHit         = (cpuAddr[31:22] == FB_BASE[31:22]);
  assign palHit        = (cpuAddr[31:6]  == PAL_BASE[31:6]);
  assign inRange       = (wordIdx < 20'(DEPTH));
  assign unusedCpuBits = ^{cpuAddr[1:0], cpuWdata[31:24]};

  assign fbWe    = cpuWe && fbHit && inRange;
  assign fbIdx   = wordIdx[IDX_W-1:0];
  assign fbData  = cpuWdata[PIX_BITS-1:0];
  assign palWe   = cpuWe && palHit;
  assign palSel  = cpuAddr[PIX_BITS+1:2];
  assign palData = cpuWdata[COLOR_BITS-1:0];
endmodule

// File: rtl/fb_scan_datapath.sv
module fb_scan_datapath
  import fb_scan_pkg::*;
#(
  parameter int DEPTH = 192,
  parameter int IDX_W = 8
) (
  input  logic             cpuClk,
  input  logic             cpuRstN,
  input  logic             fbWe,
  input  logic [IDX_W-1:0] fbIdx,
  input  pix_t             fbData,
  input  logic             palWe,
  input  logic [PIX_BITS-1:0] palSel,
  input  color_t           palData,
  input  logic             pixClk,
  input  logic             pixRstN,
  input  scan_strb_t       strobe,
  input  logic [IDX_W-1:0] rdIdx,
  output color_t           rgbOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             blankOut
);
  pix_t       fbMem [DEPTH];
  color_t     palReg [PAL_ENTRIES];
  pix_t       pixQ;
  scan_strb_t s1;

  // CPU clock domain: framebuffer write port
  always_ff @(posedge cpuClk) begin
    if (fbWe) fbMem[fbIdx] <= fbData;
  end

  // CPU clock domain: palette registers
  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      for (int e = 0; e < PAL_ENTRIES; e++) palReg[e] <= '0;
    end else begin
      for (int e = 0; e < PAL_ENTRIES; e++) begin
        if (palWe && (palSel == PIX_BITS'(e))) palReg[e] <= palData;
      end
    end
  end

  // Pixel domain stage 1: synchronous framebuffer read; strobes follow
  always_ff @(posedge pixClk) begin
    pixQ <= fbMem[rdIdx];
  end

  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) s1 <= '0;
    else          s1 <= strobe;
  end

  // Pixel domain stage 2: palette lookup and output register
  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      rgbOut   <= '0;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      blankOut <= 1'b1;
    end else begin
      rgbOut   <= s1.visible ? palReg[pixQ] : '0;
      hsyncOut <= s1.hsync;
      vsyncOut <= s1.vsync;
      blankOut <= !s1.visible;
    end
  end

  // R5: output is black whenever blank is asserted
  p_black_in_blank_r5: assert property (@(posedge pixClk) disable iff (!pixRstN)
    blankOut |-> (rgbOut == '0));

  // R3: vertical sync only ever occurs inside blanking
  p_vsync_in_blank_r3: assert property (@(posedge pixClk) disable iff (!pixRstN)
    vsyncOut |-> blankOut);

  // R7: syncs leave two pixel clocks after the raster control raised them
  p_sync_latency_r7: assert property (@(posedge pixClk) disable iff (!pixRstN)
    (hsyncOut == $past(strobe.hsync, 2)) && (vsyncOut == $past(strobe.vsync, 2)));

  // R8: no framebuffer write lands beyond the visible area
  p_fb_in_range_r8: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    fbWe |-> (int'(fbIdx) < DEPTH));
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_scan_pkg::*;
#(
  parameter int HACT  = 16,
  parameter int HFP   = 2,
  parameter int HSYNC = 3,
  parameter int HBP   = 4,
  parameter int VACT  = 12,
  parameter int VFP   = 1,
  parameter int VSYNC = 2,
  parameter int VBP   = 3
) (
  input  logic        cpuClk,
  input  logic        cpuRstN,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  input  logic        pixClk,
  input  logic        pixRstN,
  output logic [23:0] vidRgb,
  output logic        vidHsync,
  output logic        vidVsync,
  output logic        vidBlank
);
  localparam int DEPTH = HACT * VACT;
  localparam int IDX_W = $clog2(DEPTH);

  scan_strb_t              strobe;
  logic [IDX_W-1:0]        rdIdx;
  logic                    fbWe;
  logic [IDX_W-1:0]        fbIdx;
  pix_t                    fbData;
  logic                    palWe;
  logic [PIX_BITS-1:0]     palSel;
  color_t                  palData;

  fb_scan_timing #(
    .HACT(HACT), .HFP(HFP), .HSYNC(HSYNC), .HBP(HBP),
    .VACT(VACT), .VFP(VFP), .VSYNC(VSYNC), .VBP(VBP),
    .IDX_W(IDX_W)
  ) u_timing (
    .pixClk(pixClk), .pixRstN(pixRstN), .strobe(strobe), .rdIdx(rdIdx)
  );

  fb_cpu_port #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_cpu (
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .fbWe(fbWe), .fbIdx(fbIdx), .fbData(fbData),
    .palWe(palWe), .palSel(palSel), .palData(palData)
  );

  fb_scan_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dp (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN),
    .fbWe(fbWe), .fbIdx(fbIdx), .fbData(fbData),
    .palWe(palWe), .palSel(palSel), .palData(palData),
    .pixClk(pixClk), .pixRstN(pixRstN),
    .strobe(strobe), .rdIdx(rdIdx),
    .rgbOut(vidRgb), .hsyncOut(vidHsync), .vsyncOut(vidVsync), .blankOut(vidBlank)
  );
endmodule

// File: tb/fb_scanout_bench.sv
module fb_scanout_bench;
  localparam int HACT = 16, HFP = 2, HSYNC = 3, HBP = 4;
  localparam int VACT = 12, VFP = 1, VSYNC = 2, VBP = 3;
  localparam int HTOT  = HACT + HFP + HSYNC + HBP;
  localparam int VTOT  = VACT + VFP + VSYNC + VBP;
  localparam int FRAME = HTOT * VTOT;
  localparam int DEPTH = HACT * VACT;
  localparam logic [31:0] FBB = 32'h8000_0000;
  localparam logic [31:0] PLB = 32'h8040_0000;

  logic        cpuClk = 1'b0, pixClk = 1'b0;
  logic        cpuRstN = 1'b0, pixRstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [23:0] vidRgb;
  logic        vidHsync, vidVsync, vidBlank;

  fb_scanout #(.HACT(HACT), .HFP(HFP), .HSYNC(HSYNC), .HBP(HBP),
               .VACT(VACT), .VFP(VFP), .VSYNC(VSYNC), .VBP(VBP)) u_fb_scanout (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .pixClk(pixClk), .pixRstN(pixRstN),
    .vidRgb(vidRgb), .vidHsync(vidHsync), .vidVsync(vidVsync), .vidBlank(vidBlank)
  );

  always #5 pixClk = ~pixClk;
  always #7 cpuClk = ~cpuClk;

  int edgeCnt = 0;
  always @(posedge pixClk) begin
    if (!pixRstN) edgeCnt <= 0;
    else          edgeCnt <= edgeCnt + 1;
  end

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;
  logic [3:0]  modelFb  [DEPTH];
  logic [23:0] modelPal [16];

  task automatic check(input bit ok, input string what);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic cpuWrite(input logic [31:0] a, input logic [31:0] d, input bit we);
    @(negedge cpuClk);
    cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge cpuClk);
    cpuWe = 1'b0;
  endtask

  task automatic fbPut(input int x, input int y, input logic [3:0] val);
    cpuWrite(FBB + 32'(4 * (y * HACT + x)), {28'hABCDEF1, val}, 1'b1);
    modelFb[y * HACT + x] = val;
  endtask

  task automatic palPut(input int n, input logic [23:0] c);
    cpuWrite(PLB + 32'(4 * n), {8'hC3, c}, 1'b1);
    modelPal[n] = c;
  endtask

  // Leaves the bench at a negedge where the output shows frame position 0.
  task automatic waitFrameStart();
    do @(negedge pixClk);
    while (edgeCnt < 2 || ((edgeCnt - 2) % FRAME) != 0);
  endtask

  task automatic checkFrame(input string tag);
    int eBl = 0, eHs = 0, eVs = 0, eBk = 0, eAc = 0;
    int aBl = 0, xBl = 0, aHs = 0, xHs = 0, aVs = 0, xVs = 0;
    logic [23:0] aBk = '0, aAc = '0, xAc = '0;
    waitFrameStart();
    for (int i = 0; i < FRAME; i++) begin
      int h, v;
      bit vis, hs, vs;
      if (i > 0) @(negedge pixClk);
      h = i % HTOT;
      v = i / HTOT;
      vis = (h < HACT) && (v < VACT);
      hs  = (h >= HACT + HFP) && (h < HACT + HFP + HSYNC);
      vs  = (v >= VACT + VFP) && (v < VACT + VFP + VSYNC);
      if (vidBlank !== !vis) begin if (eBl == 0) begin aBl = vidBlank; xBl = !vis; end eBl++; end
      if (vidHsync !== hs)   begin if (eHs == 0) begin aHs = vidHsync; xHs = hs; end eHs++; end
      if (vidVsync !== vs)   begin if (eVs == 0) begin aVs = vidVsync; xVs = vs; end eVs++; end
      if (!vis && vidRgb !== 24'h0) begin if (eBk == 0) aBk = vidRgb; eBk++; end
      if (vis && vidRgb !== modelPal[modelFb[v * HACT + h]]) begin
        if (eAc == 0) begin aAc = vidRgb; xAc = modelPal[modelFb[v * HACT + h]]; end
        eAc++;
      end
    end
    check(eBl == 0, $sformatf("R2 blank pattern (%s): %0d errors, actual %0d expected %0d", tag, eBl, aBl, xBl));
    check(eHs == 0, $sformatf("R3 hsync pattern (%s): %0d errors, actual %0d expected %0d", tag, eHs, aHs, xHs));
    check(eVs == 0, $sformatf("R3 vsync pattern (%s): %0d errors, actual %0d expected %0d", tag, eVs, aVs, xVs));
    check(eBk == 0, $sformatf("R5 rgb in blank (%s): %0d errors, actual %h expected 000000", tag, eBk, aBk));
    check(eAc == 0, $sformatf("%s visible colour: %0d errors, actual %h expected %h", tag, eAc, aAc, xAc));
  endtask

  task automatic loadPattern();
    for (int n = 0; n < 16; n++)
      palPut(n, {8'(n * 17), 8'(8'hF0 - 8'(n * 9)), 8'(n * 5 + 3)});
    for (int y = 0; y < VACT; y++)
      for (int x = 0; x < HACT; x++)
        fbPut(x, y, 4'((x + 3 * y) % 16));
  endtask

  task automatic testReset();
    @(negedge pixClk);
    check(vidRgb == 24'h0, $sformatf("R1 rgb in reset: actual %h expected 000000", vidRgb));
    check(vidHsync == 1'b0, $sformatf("R1 hsync in reset: actual %0d expected 0", vidHsync));
    check(vidVsync == 1'b0, $sformatf("R1 vsync in reset: actual %0d expected 0", vidVsync));
    check(vidBlank == 1'b1, $sformatf("R1 blank in reset: actual %0d expected 1", vidBlank));
  endtask

  task automatic testFirstPixel();
    @(negedge pixClk);
    pixRstN = 1'b1;
    @(negedge pixClk);
    check(vidBlank == 1'b1, $sformatf("R7 blank after one edge: actual %0d expected 1", vidBlank));
    @(negedge pixClk);
    check(vidBlank == 1'b0 && vidRgb == modelPal[modelFb[0]],
          $sformatf("R7 first pixel on second edge: actual blank %0d rgb %h expected blank 0 rgb %h",
                    vidBlank, vidRgb, modelPal[modelFb[0]]));
    repeat (HACT + HFP - 1) @(negedge pixClk);
    check(vidHsync == 1'b0, $sformatf("R7 hsync before its column: actual %0d expected 0", vidHsync));
    @(negedge pixClk);
    check(vidHsync == 1'b1, $sformatf("R7 hsync at its column: actual %0d expected 1", vidHsync));
  endtask

  task automatic testIgnored();
    cpuWrite(FBB + 32'(4 * 5), 32'hF, 1'b0);                // cpuWe low
    cpuWrite(FBB + 32'(4 * DEPTH), 32'hF, 1'b1);            // first index past the screen
    cpuWrite(FBB + 32'(4 * (256 + 5)), 32'hF, 1'b1);        // would alias index 5
    cpuWrite(32'h0000_0014, 32'hF, 1'b1);                   // outside both windows
    cpuWrite(PLB + 32'h40, 32'hFF_FFFF, 1'b1);              // past the palette window
    cpuWrite(PLB + 32'h80, 32'hFF_FFFF, 1'b1);
    checkFrame("R8");
  endtask

  task automatic testPalSwap();
    for (int n = 0; n < 16; n++) palPut(n, ~modelPal[n]);
    checkFrame("R9");
  endtask

  task automatic testSinglePixel();
    int hits = 0, where = -1;
    for (int i = 0; i < DEPTH; i++) fbPut(i % HACT, i / HACT, 4'h0);
    palPut(0, 24'h0);
    palPut(9, 24'h123456);
    fbPut(3, 2, 4'h9);
    waitFrameStart();
    for (int i = 0; i < FRAME; i++) begin
      if (i > 0) @(negedge pixClk);
      if (vidRgb != 24'h0) begin
        hits++;
        if (where < 0 && vidRgb == 24'h123456) where = i;
      end
    end
    check(hits == 1 && where == 2 * HTOT + 3,
          $sformatf("R10 raster position of (3,2): actual hits %0d at %0d expected 1 at %0d",
                    hits, where, 2 * HTOT + 3));
  endtask

  initial begin
    repeat (3) @(negedge cpuClk);
    cpuRstN = 1'b1;
    loadPattern();
    testReset();
    testFirstPixel();
    checkFrame("R4/R6");
    testIgnored();
    testPalSwap();
    testSinglePixel();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge pixClk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule